// File: doc/BRIEF.md
# Coalescing Outstanding Request Table

This block keeps track of the memory requests a core has in flight and groups them by cache-line address. Each tracked line owns a small ordered queue. Only the request that finds its line's queue empty is sent to the memory hierarchy. Any later request to the same line is accepted and queued behind it without being sent. This means the core never sees a rejection just because two requests alias to one line.

When the hierarchy answers for a line, the block walks that line's queue one request per cycle and produces completions. A write answer empties the whole queue. A read answer completes loads from the head and stops at the first store-class request, which it sends downstream again. Locked read-modify-write pairs lock and unlock a line, and requests to a locked line are refused. A watchdog flags any request that has waited too long. An outstanding counter and an idle flag report how much work the table holds.

Top module: `crt_table`

## Requirements
- R1: When a request is accepted and its line has no queued requests, `dn_valid` is high for exactly one cycle, in the cycle after the handshake. In that cycle `dn_line`, `dn_sub` and `dn_id` equal the request's line, secondary kind and id.
- R2: When a request is accepted and its line already has queued requests, it is appended to that queue. It is not refused, and `dn_valid` stays low in the following cycle.
- R3: If the line is locked and the kind is not 4, a request is refused. `req_ready` and `req_refused` are both high, and the request is consumed without being queued, so `outstanding` does not change.
- R4: Kind codes are: 0 load, 1 instruction fetch, 2 store, 3 locked read-modify-write read, 4 locked read-modify-write write. Codes 2 to 4 are store-class. A response with `rsp_write` high drains the whole queue of its line in arrival order, one `cpl_valid` pulse per cycle. The first pulse comes two cycles after the response handshake.
- R5: A response with `rsp_write` low completes requests from the head of the queue while they are loads or fetches. When it reaches a store-class request, that request is sent downstream once more with its own line, id and secondary kind, and it stays queued.
- R6: Completing a kind-3 request locks its line. Completing a kind-4 request unlocks it. A locked line keeps its entry even when its queue is empty.
- R7: `outstanding` rises by one for each accepted request and falls by one for each completion. `idle` is high exactly when no line entry exists, including locked entries with empty queues.
- R8: `stuck` goes high after any clock edge at which a queued request is at least `STUCK_LIM` cycles old. Once high, it stays high until reset.
- R9: Only the first completion of each drain has `cpl_lead` high. Its `cpl_lat` is the completion cycle minus the issue cycle, or zero if `rsp_t0` is earlier than the issue cycle. All other completions report a latency of zero.
- R10: `rsp_ready` is high only while no drain is running. `req_ready` is low while a drain runs, while `rsp_valid` is high, when the target line's queue is full, and when a new line finds no free entry. A refused request is the one exception to the last two conditions.
- R11: After reset there are no pulses on `dn_valid` or `cpl_valid`, `outstanding` is zero, `idle` and `rsp_ready` are high, and `stuck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request taken this cycle (accepted or refused) |
| req_line | input | LINE_W | Line address of the request |
| req_kind | input | 3 | Primary kind code |
| req_sub | input | 3 | Secondary kind, used when sent downstream |
| req_id | input | ID_W | Request tag |
| req_refused | output | 1 | Taken request refused because its line is locked |
| dn_valid | output | 1 | Downstream send pulse |
| dn_line | output | LINE_W | Line of the sent request |
| dn_sub | output | 3 | Secondary kind of the sent request |
| dn_id | output | ID_W | Tag of the sent request |
| rsp_valid | input | 1 | Hierarchy response present |
| rsp_ready | output | 1 | Response can be taken |
| rsp_line | input | LINE_W | Line the response belongs to |
| rsp_write | input | 1 | 1 for a write response, 0 for a read response |
| rsp_t0 | input | TS_W | Initial-request time reported with the response |
| cpl_valid | output | 1 | Completion pulse |
| cpl_id | output | ID_W | Tag of the completed request |
| cpl_kind | output | 3 | Primary kind of the completed request |
| cpl_lead | output | 1 | Completion is the head of its downstream transaction |
| cpl_lat | output | TS_W | Latency of the lead completion, else zero |
| outstanding | output | clog2(NUM_LINES*QDEPTH+1) | Requests currently queued |
| idle | output | 1 | No line entry in use |
| stuck | output | 1 | Sticky watchdog flag |

## Verification
The stimulus mixes loads, fetches, stores and locked read-modify-write kinds across three lines with only two entries. Queues therefore alias, fill up and run out of entries, which separates the sending of first requests from the silent queuing of later ones. Read responses that meet a queued store set the stop-and-resend path apart from the full drain of a write response. Response times are chosen either before or after the head's issue cycle, which exercises both latency rules. A final phase releases every lock and then leaves one load unanswered past the watchdog limit.

// File: rtl/crt_pkg.sv
// Shared kind codes, drain state type and kind classification helper.
// Assumes kinds are 3-bit codes; everything that is not a load or fetch
// is treated as store-class.
package crt_pkg;
    localparam logic [2:0] KIND_LOAD  = 3'd0;
    localparam logic [2:0] KIND_FETCH = 3'd1;
    localparam logic [2:0] KIND_STORE = 3'd2;
    localparam logic [2:0] KIND_LKRD  = 3'd3;
    localparam logic [2:0] KIND_LKWR  = 3'd4;

    typedef enum logic {ST_IDLE, ST_DRAIN} crt_state_e;

    function automatic logic is_store_class(input logic [2:0] k);
        return !(k == KIND_LOAD || k == KIND_FETCH);
    endfunction
endpackage

// File: rtl/crt_match.sv
// Associative lookup: finds the valid entry whose line tag equals the key.
// Assumes at most one valid entry per line (the table guarantees it).
module crt_match #(
    parameter int N  = 4,
    parameter int LW = 8,
    parameter int IW = 2
) (
    input  logic [N-1:0]         ent_v,
    input  logic [N-1:0][LW-1:0] ent_tag,
    input  logic [LW-1:0]        key,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx
);
    // lowest-index match wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!hit && ent_v[i] && ent_tag[i] == key) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/crt_watchdog.sv
// Age scan over every queue slot. A slot is occupied when its distance
// from the entry's head pointer is below the entry's count. Assumes D is
// a power of two and that ages fit in TW bits of modular arithmetic.
module crt_watchdog #(
    parameter int N   = 4,
    parameter int D   = 4,
    parameter int TW  = 16,
    parameter int LIM = 1000,
    parameter int PW  = 2,
    parameter int CW  = 3
) (
    input  logic [N-1:0]          ent_v,
    input  logic [N-1:0][PW-1:0]  ent_hd,
    input  logic [N-1:0][CW-1:0]  ent_cnt,
    input  logic [N*D-1:0][TW-1:0] slot_ts,
    input  logic [TW-1:0]         now,
    output logic                  over
);
    logic [N*D-1:0] old_slot;

    for (genvar e = 0; e < N; e++) begin : g_ent
        for (genvar s = 0; s < D; s++) begin : g_slot
            logic [PW-1:0] rel;
            logic [TW-1:0] age;
            // occupancy and age test for one slot
            assign rel = PW'(s) - ent_hd[e];
            assign age = now - slot_ts[e*D+s];
            assign old_slot[e*D+s] = ent_v[e] && (CW'(rel) < ent_cnt[e])
                                     && (age >= TW'(LIM));
        end
    end

    assign over = |old_slot;
endmodule

// File: rtl/crt_table.sv
// Outstanding request table with per-line coalescing queues.
// Accepts one request per cycle when no drain runs. It sends only the
// request that finds its queue empty and queues the rest. A response
// starts a drain that handles one queue slot per cycle. Assumes
// NUM_LINES and QDEPTH are powers of two (at least 2), and that at most
// one downstream transaction per line is open at a time. A response for
// a line with no entry is dropped.
module crt_table
    import crt_pkg::*;
#(
    parameter int LINE_W    = 8,
    parameter int ID_W      = 4,
    parameter int TS_W      = 16,
    parameter int NUM_LINES = 4,
    parameter int QDEPTH    = 4,
    parameter int STUCK_LIM = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LINE_W-1:0] req_line,
    input  logic [2:0]        req_kind,
    input  logic [2:0]        req_sub,
    input  logic [ID_W-1:0]   req_id,
    output logic              req_refused,
    output logic              dn_valid,
    output logic [LINE_W-1:0] dn_line,
    output logic [2:0]        dn_sub,
    output logic [ID_W-1:0]   dn_id,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [LINE_W-1:0] rsp_line,
    input  logic              rsp_write,
    input  logic [TS_W-1:0]   rsp_t0,
    output logic              cpl_valid,
    output logic [ID_W-1:0]   cpl_id,
    output logic [2:0]        cpl_kind,
    output logic              cpl_lead,
    output logic [TS_W-1:0]   cpl_lat,
    output logic [$clog2(NUM_LINES*QDEPTH+1)-1:0] outstanding,
    output logic              idle,
    output logic              stuck
);
    localparam int EW = $clog2(NUM_LINES);
    localparam int PW = $clog2(QDEPTH);
    localparam int CW = $clog2(QDEPTH+1);
    localparam int NS = NUM_LINES*QDEPTH;
    localparam int SW = EW+PW;
    localparam int OW = $clog2(NS+1);

    // line entries
    logic [NUM_LINES-1:0]             ent_v, ent_lock;
    logic [NUM_LINES-1:0][LINE_W-1:0] ent_line;
    logic [NUM_LINES-1:0][PW-1:0]     ent_hd;
    logic [NUM_LINES-1:0][CW-1:0]     ent_cnt;
    // queue slots, index {entry, slot}
    logic [2:0]        s_kind [NS];
    logic [2:0]        s_sub  [NS];
    logic [ID_W-1:0]   s_id   [NS];
    logic [NS-1:0][TS_W-1:0] s_ts;

    crt_state_e      st;
    logic [EW-1:0]   d_e;
    logic            d_wr, d_first;
    logic [TS_W-1:0] d_t0, cyc;

    logic          lk_hit, rs_hit, fr_ok, refuse_c, room, acc, wd_over;
    logic [EW-1:0] lk_idx, rs_idx, fr_idx, tgt;
    logic [PW-1:0] tail;
    logic [SW-1:0] wsl, hsl;
    logic          lock_nx;

    crt_match #(.N(NUM_LINES), .LW(LINE_W), .IW(EW)) u_req_match (
        .ent_v(ent_v), .ent_tag(ent_line), .key(req_line),
        .hit(lk_hit), .hit_idx(lk_idx));

    crt_match #(.N(NUM_LINES), .LW(LINE_W), .IW(EW)) u_rsp_match (
        .ent_v(ent_v), .ent_tag(ent_line), .key(rsp_line),
        .hit(rs_hit), .hit_idx(rs_idx));

    crt_watchdog #(.N(NUM_LINES), .D(QDEPTH), .TW(TS_W), .LIM(STUCK_LIM),
                   .PW(PW), .CW(CW)) u_wd (
        .ent_v(ent_v), .ent_hd(ent_hd), .ent_cnt(ent_cnt),
        .slot_ts(s_ts), .now(cyc), .over(wd_over));

    // lowest free entry for a line seen for the first time
    always_comb begin
        fr_ok  = 1'b0;
        fr_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (!fr_ok && !ent_v[i]) begin
                fr_ok  = 1'b1;
                fr_idx = EW'(i);
            end
        end
    end

    // accept-side decisions: refusal, room, write slot
    always_comb begin
        refuse_c    = req_valid && lk_hit && ent_lock[lk_idx] && req_kind != KIND_LKWR;
        room        = lk_hit ? (ent_cnt[lk_idx] < CW'(QDEPTH)) : fr_ok;
        rsp_ready   = (st == ST_IDLE);
        req_ready   = (st == ST_IDLE) && !rsp_valid && (refuse_c || room);
        req_refused = req_valid && req_ready && refuse_c;
        acc         = req_valid && req_ready && !refuse_c;
        tgt         = lk_hit ? lk_idx : fr_idx;
        tail        = lk_hit ? ent_hd[lk_idx] + PW'(ent_cnt[lk_idx]) : '0;
        wsl         = {tgt, tail};
        hsl         = {d_e, ent_hd[d_e]};
        lock_nx     = (s_kind[hsl] == KIND_LKRD) ? 1'b1 :
                      (s_kind[hsl] == KIND_LKWR) ? 1'b0 : ent_lock[d_e];
    end

    assign outstanding = OW'(0) + outstanding_q;
    logic [OW-1:0] outstanding_q;
    assign idle = ~|ent_v;

    // table state, accept path, drain sequencer and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0; ent_lock <= '0; ent_line <= '0;
            ent_hd <= '0; ent_cnt <= '0; s_ts <= '0;
            for (int i = 0; i < NS; i++) begin
                s_kind[i] <= '0; s_sub[i] <= '0; s_id[i] <= '0;
            end
            st <= ST_IDLE; d_e <= '0; d_wr <= 1'b0; d_first <= 1'b0; d_t0 <= '0;
            cyc <= '0; stuck <= 1'b0; outstanding_q <= '0;
            dn_valid <= 1'b0; dn_line <= '0; dn_sub <= '0; dn_id <= '0;
            cpl_valid <= 1'b0; cpl_id <= '0; cpl_kind <= '0;
            cpl_lead <= 1'b0; cpl_lat <= '0;
        end else begin
            cyc       <= cyc + 1'b1;
            dn_valid  <= 1'b0;
            cpl_valid <= 1'b0;
            if (wd_over) stuck <= 1'b1;
            if (acc) begin
                if (!lk_hit) begin
                    ent_v[tgt]    <= 1'b1;
                    ent_lock[tgt] <= 1'b0;
                    ent_line[tgt] <= req_line;
                    ent_hd[tgt]   <= '0;
                end
                s_kind[wsl]   <= req_kind;
                s_sub[wsl]    <= req_sub;
                s_id[wsl]     <= req_id;
                s_ts[wsl]     <= cyc;
                ent_cnt[tgt]  <= (lk_hit ? ent_cnt[tgt] : CW'(0)) + 1'b1;
                outstanding_q <= outstanding_q + 1'b1;
                if (!lk_hit || ent_cnt[tgt] == '0) begin
                    dn_valid <= 1'b1;
                    dn_line  <= req_line;
                    dn_sub   <= req_sub;
                    dn_id    <= req_id;
                end
            end
            case (st)
                ST_IDLE: if (rsp_valid && rs_hit) begin
                    st      <= ST_DRAIN;
                    d_e     <= rs_idx;
                    d_wr    <= rsp_write;
                    d_t0    <= rsp_t0;
                    d_first <= 1'b1;
                end
                ST_DRAIN: begin
                    if (ent_cnt[d_e] == '0) begin
                        st <= ST_IDLE;
                        if (!ent_lock[d_e]) ent_v[d_e] <= 1'b0;
                    end else if (!d_wr && is_store_class(s_kind[hsl])) begin
                        dn_valid <= 1'b1;
                        dn_line  <= ent_line[d_e];
                        dn_sub   <= s_sub[hsl];
                        dn_id    <= s_id[hsl];
                        st       <= ST_IDLE;
                    end else begin
                        cpl_valid     <= 1'b1;
                        cpl_id        <= s_id[hsl];
                        cpl_kind      <= s_kind[hsl];
                        cpl_lead      <= d_first;
                        cpl_lat       <= (!d_first || d_t0 < s_ts[hsl]) ? '0
                                         : cyc - s_ts[hsl];
                        ent_hd[d_e]   <= ent_hd[d_e] + 1'b1;
                        ent_cnt[d_e]  <= ent_cnt[d_e] - 1'b1;
                        ent_lock[d_e] <= lock_nx;
                        outstanding_q <= outstanding_q - 1'b1;
                        d_first       <= 1'b0;
                        if (ent_cnt[d_e] == CW'(1)) begin
                            st <= ST_IDLE;
                            if (!lock_nx) ent_v[d_e] <= 1'b0;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crt_table_chk.sv
// Protocol and state checks for crt_table, attached by bind.
module crt_table_chk #(
    parameter int OW = 4,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          req_refused,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic          dn_valid,
    input logic          cpl_valid,
    input logic          cpl_lead,
    input logic [TW-1:0] cpl_lat,
    input logic [OW-1:0] outstanding,
    input logic          idle,
    input logic          stuck
);
    // R3
    refuse_no_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_refused |=> outstanding == $past(outstanding));
    // R5
    send_or_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_valid && cpl_valid));
    // R10
    req_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> rsp_ready);
    // R4
    drain_blocks_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> !rsp_ready);
    // R7
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> outstanding == '0);
    // R8
    stuck_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuck |=> stuck);
    // R9
    follower_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_lead |-> cpl_lat == '0);
endmodule

bind crt_table crt_table_chk #(.OW(OW), .TW(TS_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_refused(req_refused),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .dn_valid(dn_valid),
    .cpl_valid(cpl_valid), .cpl_lead(cpl_lead), .cpl_lat(cpl_lat),
    .outstanding(outstanding), .idle(idle), .stuck(stuck));

// File: tb/test_crt_table.sv
// Bench: behavioural queue model stepped once per clock and compared on
// every cycle; a responder answers open downstream transactions.
module test_crt_table;
    localparam int LW = 8, IW = 4, TW = 16, NL = 2, QD = 4, LIM = 150;
    localparam int OW = $clog2(NL*QD+1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_refused;
    logic [LW-1:0] req_line = '0;
    logic [2:0] req_kind = '0, req_sub = '0;
    logic [IW-1:0] req_id = '0;
    logic dn_valid; logic [LW-1:0] dn_line; logic [2:0] dn_sub; logic [IW-1:0] dn_id;
    logic rsp_valid = 1'b0, rsp_ready, rsp_write = 1'b0;
    logic [LW-1:0] rsp_line = '0; logic [TW-1:0] rsp_t0 = '0;
    logic cpl_valid, cpl_lead; logic [IW-1:0] cpl_id; logic [2:0] cpl_kind;
    logic [TW-1:0] cpl_lat; logic [OW-1:0] outstanding; logic idle, stuck;

    always #2 clk = ~clk;

    crt_table #(.LINE_W(LW), .ID_W(IW), .TS_W(TW), .NUM_LINES(NL),
                .QDEPTH(QD), .STUCK_LIM(LIM)) i_crt_table (.*);

    typedef struct { int kind; int sub; int id; int ts; } rr_t;
    rr_t mq [8][$];
    bit  mlock [8];
    int  m_out = 0, m_st = 0, m_dl = 0, m_dwr = 0, m_t0 = 0, m_first = 0, m_cyc = 0;
    bit  m_stuck = 0;
    int  e_dn = 0, e_dn_line = 0, e_dn_sub = 0, e_dn_id = 0;
    int  e_cpl = 0, e_cpl_id = 0, e_cpl_kind = 0, e_cpl_lead = 0, e_cpl_lat = 0;
    string e_dn_tag = "R1", e_cpl_tag = "R4";
    int  pend[$];
    int  rdly = 0, nvec = 0, nbad = 0, idc = 0, rq_wait = 0, gen_mode = 1;
    bit  rq_on = 0, resp_off = 0, done = 0, one_shot = 0;
    int  lines3 [3] = '{1, 2, 5};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: got %0d expected %0d at model cycle %0d", tag, act, exp, m_cyc);
        end
    endtask

    function automatic bit st_class(input int k);
        return !(k == 0 || k == 1);
    endfunction

    function automatic int nent();
        int n = 0;
        for (int l = 0; l < 8; l++) if (mq[l].size() > 0 || mlock[l]) n++;
        return n;
    endfunction

    function automatic bit quiet();
        bit q = (pend.size() == 0) && (m_st == 0) && !rq_on;
        for (int l = 0; l < 8; l++) if (mq[l].size() > 0) q = 0;
        return q;
    endfunction

    // compare registered outputs with the model's prediction for the last edge
    task automatic compare();
        chk(dn_valid == e_dn[0], e_dn_tag, dn_valid, e_dn);
        if (e_dn != 0) begin
            chk(dn_line == e_dn_line, e_dn_tag, dn_line, e_dn_line);
            chk(dn_sub == e_dn_sub, e_dn_tag, dn_sub, e_dn_sub);
            chk(dn_id == e_dn_id, e_dn_tag, dn_id, e_dn_id);
            pend.push_back(e_dn_line);
        end
        chk(cpl_valid == e_cpl[0], e_cpl_tag, cpl_valid, e_cpl);
        if (e_cpl != 0) begin
            chk(cpl_id == e_cpl_id, e_cpl_tag, cpl_id, e_cpl_id);
            chk(cpl_kind == e_cpl_kind, e_cpl_tag, cpl_kind, e_cpl_kind);
            chk(cpl_lead == e_cpl_lead[0], "R9 lead", cpl_lead, e_cpl_lead);
            chk(cpl_lat == e_cpl_lat, "R9 latency", cpl_lat, e_cpl_lat);
        end
        chk(outstanding == m_out, "R7 count", outstanding, m_out);
        chk(idle == (nent() == 0), "R7 idle", idle, nent() == 0);
        chk(stuck == m_stuck, "R8", stuck, m_stuck);
    endtask

    // drive request generator and responder for the coming edge
    task automatic drive();
        rsp_valid = 1'b0;
        if (!resp_off && pend.size() > 0) begin
            if (rdly > 0) rdly--;
            else if (mq[pend[0]].size() > 0) begin
                rr_t h = mq[pend[0]][0];
                rsp_valid = 1'b1;
                rsp_line  = LW'(pend[0]);
                rsp_write = st_class(h.kind);
                rsp_t0    = TW'((h.id % 2 == 1 || h.ts == 0) ? h.ts + 3 : h.ts - 1);
            end
        end
        if (rq_on) begin
            rq_wait++;
            if (rq_wait > 10) rq_on = 0;
        end
        if (!rq_on) begin
            if (gen_mode == 1 && $urandom % 3 != 0) begin
                int r = $urandom % 10;
                rq_on = 1; rq_wait = 0;
                req_line = LW'(lines3[$urandom % 3]);
                req_kind = (r < 4) ? 3'd0 : (r == 4) ? 3'd1 : (r < 8) ? 3'd2 : (r == 8) ? 3'd3 : 3'd4;
                req_sub  = 3'($urandom % 8);
                req_id   = IW'(idc++);
            end else if (gen_mode == 2) begin
                for (int l = 0; l < 8; l++) if (!rq_on && mlock[l]) begin
                    rq_on = 1; rq_wait = 0; req_line = LW'(l);
                    req_kind = 3'd4; req_sub = 3'd6; req_id = IW'(idc++);
                end
            end else if (gen_mode == 3 && !one_shot) begin
                one_shot = 1; rq_on = 1; rq_wait = 0; req_line = LW'(6);
                req_kind = 3'd0; req_sub = 3'd1; req_id = IW'(idc++);
            end
        end
        req_valid = rq_on;
    endtask

    // predict ready signals, then advance the model across the next edge
    task automatic step();
        int  L = int'(req_line);
        bit  refuse = req_valid && mlock[L] && req_kind != 3'd4;
        bit  hasent = mq[L].size() > 0 || mlock[L];
        bit  room   = hasent ? (mq[L].size() < QD) : (nent() < NL);
        bit  x_rr   = (m_st == 0) && !rsp_valid && (refuse || room);
        chk(rsp_ready == (m_st == 0), "R10 rsp_ready", rsp_ready, m_st == 0);
        chk(req_ready == x_rr, "R10 req_ready", req_ready, x_rr);
        chk(req_refused == (req_valid && x_rr && refuse), "R3 R6 refuse",
            req_refused, req_valid && x_rr && refuse);
        for (int l = 0; l < 8; l++)
            foreach (mq[l][i]) if (m_cyc - mq[l][i].ts >= LIM) m_stuck = 1;
        e_dn = 0; e_cpl = 0;
        if (req_valid && x_rr) begin
            if (!refuse) begin
                rr_t n;
                n.kind = int'(req_kind); n.sub = int'(req_sub);
                n.id = int'(req_id); n.ts = m_cyc;
                if (mq[L].size() == 0) begin
                    e_dn = 1; e_dn_line = L; e_dn_sub = n.sub; e_dn_id = n.id; e_dn_tag = "R1";
                end else e_dn_tag = "R2";
                mq[L].push_back(n);
                m_out++;
            end
            rq_on = 0;
        end
        if (m_st == 0) begin
            if (rsp_valid) begin
                m_st = 1; m_dl = int'(rsp_line); m_dwr = rsp_write;
                m_t0 = int'(rsp_t0); m_first = 1; pend.pop_front();
                rdly = $urandom % 6;
            end
        end else if (mq[m_dl].size() == 0) begin
            m_st = 0;
        end else begin
            rr_t h = mq[m_dl][0];
            if (m_dwr == 0 && st_class(h.kind)) begin
                e_dn = 1; e_dn_line = m_dl; e_dn_sub = h.sub; e_dn_id = h.id; e_dn_tag = "R5";
                m_st = 0;
            end else begin
                e_cpl = 1; e_cpl_id = h.id; e_cpl_kind = h.kind; e_cpl_lead = m_first;
                e_cpl_lat = (m_first == 0 || m_t0 < h.ts) ? 0 : m_cyc - h.ts;
                e_cpl_tag = m_dwr ? "R4" : "R5";
                if (h.kind == 3) mlock[m_dl] = 1;
                if (h.kind == 4) mlock[m_dl] = 0;
                void'(mq[m_dl].pop_front());
                m_out--; m_first = 0;
                if (mq[m_dl].size() == 0) m_st = 0;
            end
        end
        m_cyc++;
    endtask

    task automatic cycle();
        @(negedge clk);
        compare();
        drive();
        #1;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: state held by reset
        chk(dn_valid == 1'b0, "R11 dn_valid", dn_valid, 0);
        chk(cpl_valid == 1'b0, "R11 cpl_valid", cpl_valid, 0);
        chk(outstanding == '0, "R11 outstanding", outstanding, 0);
        chk(idle == 1'b1, "R11 idle", idle, 1);
        chk(rsp_ready == 1'b1, "R11 rsp_ready", rsp_ready, 1);
        chk(stuck == 1'b0, "R11 stuck", stuck, 0);
        rst_n = 1'b1;
        drive(); #1; step();
        repeat (3000) cycle();
        gen_mode = 0;
        for (int i = 0; i < 600 && !quiet(); i++) cycle();
        gen_mode = 2;
        for (int i = 0; i < 600 && (nent() != 0 || !quiet()); i++) cycle();
        gen_mode = 0;
        cycle();
        chk(idle == 1'b1, "R7 final idle", idle, 1);
        chk(outstanding == '0, "R7 final count", outstanding, 0);
        gen_mode = 3; resp_off = 1;
        repeat (LIM + 12) cycle();
        chk(stuck == 1'b1, "R8 unanswered load", stuck, 1);
        resp_off = 0; gen_mode = 0;
        for (int i = 0; i < 100 && !quiet(); i++) cycle();
        cycle();
        chk(stuck == 1'b1, "R8 held", stuck, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run did not end, got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule